// File: doc/BRIEF.md
# Masked-key content-addressable memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide, that is looked up by content instead of by address. A search compares an argument word against every stored entry in the same clock edge. A key register works as a per-column mask: only the bit positions whose key bit is 1 take part in the comparison. The outcome is captured in a match register that has one bit per entry.

Software-side logic or a neighbouring controller loads the argument and key registers and writes entries by index, with a valid flag for each entry. It then pulses a search strobe. Besides the raw match vector, the block gives an any-match flag and the index of the lowest matching entry. A readout port walks through the matched entries in ascending index order. Each entry read is retired with a one-cycle advance strobe.

Top module: `masked_cam_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every entry's valid flag, the match register, the readout list, and the argument and key registers to zero. After reset, a search with any key reports no match.
- R2: With the key register all ones, bit i of `match_vec` after a search is 1 exactly when entry i is valid and its stored word equals the argument in every bit.
- R3: Columns whose key bit is 0 are ignored: entries that differ from the argument only in such columns still match.
- R4: A difference in any column whose key bit is 1 clears that entry's match bit.
- R5: An invalid entry never sets its match bit, even with a key of all zeros. With a key of all zeros, every valid entry matches.
- R6: `match_vec` loads on the rising edge where `search` is high and holds its value on every other edge, including edges with entry writes. A search uses the argument and key held before any load on that same edge.
- R7: A write to entry i on the same edge as a search is seen by the search (write-first), for both the new data and the new valid flag.
- R8: `any_match` is 1 exactly when `match_vec` is non-zero. `hit_idx` is the lowest set index of `match_vec`, and 0 when there is none.
- R9: After a search, `rd_valid`/`rd_idx`/`rd_data` present the lowest-index matched entry not yet retired, with `rd_data` showing that entry's current contents. `rd_next` retires it, so the next higher match follows. `rd_next` with an empty list does nothing. A search on the same edge as `rd_next` reloads the whole list.
- R10: A write with `wr_valid` = 0 invalidates the entry, and the entry then no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arg_load | input | 1 | Load `arg_in` into the argument register |
| arg_in | input | WIDTH | New argument value |
| key_load | input | 1 | Load `key_in` into the key register |
| key_in | input | WIDTH | New column mask value (1 = compare column) |
| wr_en | input | 1 | Write entry `wr_idx` |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_data | input | WIDTH | Data for the write |
| wr_valid | input | 1 | Valid flag given to the written entry |
| search | input | 1 | Start a search on this edge |
| match_vec | output | WORDS | Match register, one bit per entry |
| any_match | output | 1 | At least one match bit set |
| hit_idx | output | IDX_W | Lowest matching entry index |
| rd_next | input | 1 | Retire the presented readout entry |
| rd_valid | output | 1 | Readout list not empty |
| rd_idx | output | IDX_W | Index of the presented matched entry |
| rd_data | output | WIDTH | Current contents of entry `rd_idx` |

## Verification
The hardest case to reach from the ports is a match that depends only on masked columns, with several entries hit at once, while a same-edge write changes one of them. Pure random data almost never produces such a hit. The stimulus therefore builds each new argument from a stored entry with random flips confined to the columns the current key masks out. It also writes copies of the argument into entries, and sparse random keys are ANDed from two draws. Directed steps cover write-first data and invalidation during a search, a key of all zeros against invalid entries, and a readout advance that collides with a new search.

// File: rtl/masked_cam_pkg.sv
package masked_cam_pkg;

  localparam int unsigned CAM_MAX_BITS = 64;

  typedef logic [CAM_MAX_BITS-1:0] cam_wide_t;

  // True when every column selected by key agrees between arg and word.
  function automatic logic cam_masked_equal(cam_wide_t arg, cam_wide_t key, cam_wide_t word);
    return ((arg ^ word) & key) == '0;
  endfunction

  // Lowest set position of vec within the first span bits, 0 if none.
  function automatic int unsigned cam_lowest_set(cam_wide_t vec, int unsigned span);
    int unsigned pos;
    pos = 0;
    for (int i = CAM_MAX_BITS - 1; i >= 0; i--) begin
      if ((i < span) && vec[i]) pos = i;
    end
    return pos;
  endfunction

endpackage

// File: rtl/cam_row.sv
module cam_row
  import masked_cam_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned ROW   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] arg_q,
  input  logic [WIDTH-1:0] key_q,
  output logic [WIDTH-1:0] stored,
  output logic             eff_valid,
  output logic             hit
);

  logic             sel;
  logic             valid_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] eff_data;

  assign sel = wr_en && (wr_idx == IDX_W'(ROW));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (sel) begin
      valid_q <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (sel) data_q <= wr_data;
  end

  // Write-first view used by a search on the same edge.
  assign eff_data  = sel ? wr_data  : data_q;
  assign eff_valid = sel ? wr_valid : valid_q;
  assign stored    = data_q;
  assign hit       = eff_valid &&
                     cam_masked_equal(cam_wide_t'(arg_q), cam_wide_t'(key_q), cam_wide_t'(eff_data));

endmodule

// File: rtl/cam_lowest.sv
module cam_lowest
  import masked_cam_pkg::*;
#(
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [WORDS-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);

  assign idx   = IDX_W'(cam_lowest_set(cam_wide_t'(vec), WORDS));
  assign found = |vec;

endmodule

// File: rtl/cam_readout.sv
module cam_readout #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             search,
  input  logic [WORDS-1:0] match_next,
  input  logic             rd_next,
  output logic [WORDS-1:0] pend_vec,
  output logic             rd_valid,
  output logic [IDX_W-1:0] rd_idx
);

  logic [WORDS-1:0] pend_q;

  cam_lowest #(.WORDS(WORDS), .IDX_W(IDX_W)) u_next (
    .vec   (pend_q),
    .idx   (rd_idx),
    .found (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (search) begin
      pend_q <= match_next;
    end else if (rd_next && rd_valid) begin
      pend_q[rd_idx] <= 1'b0;
    end
  end

  assign pend_vec = pend_q;

endmodule

// File: rtl/masked_cam_top.sv
module masked_cam_top #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arg_load,
  input  logic [WIDTH-1:0] arg_in,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_in,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  input  logic             search,
  output logic [WORDS-1:0] match_vec,
  output logic             any_match,
  output logic [IDX_W-1:0] hit_idx,
  input  logic             rd_next,
  output logic             rd_valid,
  output logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] arg_q;
  logic [WIDTH-1:0] key_q;
  logic [WORDS-1:0] hit_now;
  logic [WORDS-1:0] eff_valid;
  logic [WORDS-1:0] match_q;
  logic [WORDS-1:0] pend_vec;
  logic [WIDTH-1:0] row_data [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q <= '0;
      key_q <= '0;
    end else begin
      if (arg_load) arg_q <= arg_in;
      if (key_load) key_q <= key_in;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_row
    cam_row #(.WIDTH(WIDTH), .IDX_W(IDX_W), .ROW(g)) u_row (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .wr_valid  (wr_valid),
      .arg_q     (arg_q),
      .key_q     (key_q),
      .stored    (row_data[g]),
      .eff_valid (eff_valid[g]),
      .hit       (hit_now[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else if (search) begin
      match_q <= hit_now;
    end
  end

  assign match_vec = match_q;

  cam_lowest #(.WORDS(WORDS), .IDX_W(IDX_W)) u_hit (
    .vec   (match_q),
    .idx   (hit_idx),
    .found (any_match)
  );

  cam_readout #(.WORDS(WORDS), .IDX_W(IDX_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .search     (search),
    .match_next (hit_now),
    .rd_next    (rd_next),
    .pend_vec   (pend_vec),
    .rd_valid   (rd_valid),
    .rd_idx     (rd_idx)
  );

  assign rd_data = row_data[rd_idx];

endmodule

// File: rtl/masked_cam_chk.sv
module masked_cam_chk #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             search,
  input logic             rd_next,
  input logic [WORDS-1:0] eff_valid,
  input logic [WORDS-1:0] match_vec,
  input logic             any_match,
  input logic [IDX_W-1:0] hit_idx,
  input logic             rd_valid,
  input logic [IDX_W-1:0] rd_idx,
  input logic [WORDS-1:0] pend_vec
);

  p_match_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !search |=> $stable(match_vec));

  p_invalid_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    search |=> ((match_vec & ~$past(eff_valid)) == '0));

  p_any_points_r8: assert property (@(posedge clk) disable iff (rst)
    any_match |-> match_vec[hit_idx]);

  p_none_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !any_match |-> (match_vec == '0));

  p_lowest_r8: assert property (@(posedge clk) disable iff (rst)
    any_match |-> ((match_vec & ((WORDS'(1) << hit_idx) - WORDS'(1))) == '0));

  p_pending_subset_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & ~match_vec) == '0);

  p_rd_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_next && !search) |=> !pend_vec[$past(rd_idx)]);

endmodule

bind masked_cam_top masked_cam_chk #(.WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .search    (search),
  .rd_next   (rd_next),
  .eff_valid (eff_valid),
  .match_vec (match_vec),
  .any_match (any_match),
  .hit_idx   (hit_idx),
  .rd_valid  (rd_valid),
  .rd_idx    (rd_idx),
  .pend_vec  (pend_vec)
);

// File: tb/masked_cam_top_bench.sv
module masked_cam_top_bench;
  localparam int WORDS = 8;
  localparam int WIDTH = 16;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst, arg_load, key_load, wr_en, wr_valid, search, rd_next;
  logic [WIDTH-1:0] arg_in, key_in, wr_data;
  logic [IDX_W-1:0] wr_idx;
  logic [WORDS-1:0] match_vec;
  logic any_match, rd_valid;
  logic [IDX_W-1:0] hit_idx, rd_idx;
  logic [WIDTH-1:0] rd_data;

  always #5 clk = ~clk;

  masked_cam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) u_masked_cam_top (
    .clk(clk), .rst(rst), .arg_load(arg_load), .arg_in(arg_in),
    .key_load(key_load), .key_in(key_in), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_valid(wr_valid), .search(search),
    .match_vec(match_vec), .any_match(any_match), .hit_idx(hit_idx),
    .rd_next(rd_next), .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  logic [WIDTH-1:0] ref_data [WORDS];
  logic [WORDS-1:0] ref_valid, ref_match, ref_pend;
  logic [WIDTH-1:0] ref_arg, ref_key;
  int n_vec = 0;
  int n_bad = 0;

  function automatic int ref_lowest(logic [WORDS-1:0] v);
    for (int i = 0; i < WORDS; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit ref_hit(int i);
    if (!ref_valid[i]) return 1'b0;
    for (int j = 0; j < WIDTH; j++)
      if (ref_key[j] && (ref_arg[j] != ref_data[i][j])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    arg_load = 0; key_load = 0; wr_en = 0; wr_valid = 0;
    search = 0; rd_next = 0;
  endtask

  task automatic step(string tag);
    logic [WORDS-1:0] m;
    @(posedge clk);
    if (rst) begin
      ref_valid = '0; ref_match = '0; ref_pend = '0; ref_arg = '0; ref_key = '0;
    end else begin
      if (wr_en) begin ref_data[wr_idx] = wr_data; ref_valid[wr_idx] = wr_valid; end
      if (search) begin
        for (int i = 0; i < WORDS; i++) m[i] = ref_hit(i);
        ref_match = m; ref_pend = m;
      end else if (rd_next && ref_pend != '0) begin
        ref_pend[ref_lowest(ref_pend)] = 1'b0;
      end
      if (arg_load) ref_arg = arg_in;
      if (key_load) ref_key = key_in;
    end
    @(negedge clk);
    idle();
    rst = 0;
    check({tag, " match_vec"}, 64'(match_vec), 64'(ref_match));
    check({tag, " any_match"}, 64'(any_match), 64'(ref_match != '0));
    check({tag, " hit_idx"}, 64'(hit_idx), 64'(ref_lowest(ref_match)));
    check({tag, " rd_valid"}, 64'(rd_valid), 64'(ref_pend != '0));
    if (ref_pend != '0) begin
      check({tag, " rd_idx"}, 64'(rd_idx), 64'(ref_lowest(ref_pend)));
      check({tag, " rd_data"}, 64'(rd_data), 64'(ref_data[ref_lowest(ref_pend)]));
    end
  endtask

  task automatic put(int idx, logic [WIDTH-1:0] d, logic v, string tag);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_data = d; wr_valid = v;
    step(tag);
  endtask

  task automatic setup(logic [WIDTH-1:0] a, logic [WIDTH-1:0] k, string tag);
    arg_load = 1; arg_in = a; key_load = 1; key_in = k;
    step(tag);
  endtask

  task automatic find(string tag);
    search = 1;
    step(tag);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < WORDS; i++) ref_data[i] = '0;
    idle();
    arg_in = '0; key_in = '0; wr_data = '0; wr_idx = '0;
    rst = 1;
    @(negedge clk);
    rst = 1; step("R1 reset");
    find("R1/R5 search after reset");

    put(0, 16'h1234, 1, "R6 write w0");
    put(1, 16'hABCD, 1, "R6 write w1");
    put(2, 16'h1234, 1, "R6 write w2");
    put(3, 16'h12FF, 1, "R6 write w3");
    setup(16'h1234, 16'hFFFF, "R6 load");
    find("R2 exact match");
    setup(16'h12AA, 16'hFF00, "R6 load");
    find("R3 masked low byte");
    setup(16'h12FF, 16'h00FF, "R6 load");
    find("R4 unmasked mismatch");
    setup(16'h0000, 16'h0000, "R6 load");
    find("R5 key zero");
    put(0, 16'h1234, 0, "R6 hold on write");
    find("R10 invalidated entry");
    for (int k = 0; k < 5; k++) begin
      rd_next = 1; step("R9 readout walk");
    end
    setup(16'h5555, 16'hFFFF, "R6 load");
    wr_en = 1; wr_idx = 3'd5; wr_data = 16'h5555; wr_valid = 1; search = 1;
    step("R7 write-first data");
    put(2, 16'h5555, 1, "R6 hold after search");
    wr_en = 1; wr_idx = 3'd2; wr_data = 16'h5555; wr_valid = 0; search = 1;
    step("R7 write-first invalidate");
    setup(16'h0000, 16'h0000, "R6 load");
    find("R9 refill");
    rd_next = 1; step("R9 advance");
    rd_next = 1; search = 1; step("R9 search beats advance");
    arg_load = 1; arg_in = 16'hABCD; key_load = 1; key_in = 16'hFFFF; search = 1;
    step("R6 search uses old arg");
    find("R2 new arg");

    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 30) begin
        wr_en = 1; wr_idx = IDX_W'($urandom);
        wr_data = ($urandom % 2) ? ref_arg ^ (WIDTH'($urandom) & ~ref_key) : WIDTH'($urandom);
        wr_valid = ($urandom % 8) != 0;
      end
      if (($urandom % 4) == 0) begin
        arg_load = 1;
        arg_in = ref_data[$urandom % WORDS] ^ (WIDTH'($urandom) & ~ref_key);
      end
      if (($urandom % 5) == 0) begin
        key_load = 1;
        key_in = (($urandom % 4) == 0) ? '1 : WIDTH'($urandom) & WIDTH'($urandom);
      end
      search = ($urandom % 100) < 40;
      rd_next = ($urandom % 100) < 30;
      step("R2/R3/R4/R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule